// File: doc/BRIEF.md
# Closest-Frequency Divider Pair Search Engine

This block turns a requested pixel-clock period, given in picoseconds, into a 16-bit synthesizer programming word. It first derives the requested frequency in units of 0.01 MHz and clamps it into the supported band. It then tries every pairing of a reference divider M and a feedback divider N, one pairing at a time. For each pairing it computes the output frequency in fixed point, with 8 fractional bits, and keeps the pairing whose absolute error against the request is smallest.

The winning pair is packed together with a power-of-two post-divider exponent K. A caller pulses `start` with a period on `period_ps`. Some thousands of cycles later the engine raises `done` for one cycle, and from that cycle `word` holds the result. Each candidate runs through a small sequential divider, so one large multi-cycle datapath is shared across the whole scan. The block does not program any device with the word.

Top module: `mn_search_engine`

## Requirements
- R1: While reset is held and right after it is released, `done` is 0 and `word` is 0x0000.
- R2: The requested frequency F is floor(100000000 / period_ps) in 0.01 MHz units. A period of zero makes the quotient all ones, so the request lands on the upper clamp.
- R3: When F is zero (period above 100000000 ps), no scan runs. The engine pulses `done` within 16 cycles of `start` with `word` = 0x00E0.
- R4: A nonzero F is clamped to the band 8000..15938 before any further use.
- R5: K is the number of doublings needed to lift the clamped F to at least 64000. K is always 3 inside the band. The word is (K<<6) + M + (N<<8): bits 15:8 carry N, bits 7:6 carry K, bit 5 is 0, and bits 4:0 carry M.
- R6: The candidate frequency is floor(938356 x (N+8) / (2^K x 256 x (M+2))). It is compared with the target floor(clampedF x 256 / 100), which is taken before any doubling.
- R7: M walks 2..30 in the outer loop and N walks 35..247 in the inner loop. The best error starts as all ones. A candidate replaces the best only if its absolute error is strictly smaller, so the earliest minimum wins.
- R8: `done` is high for exactly one cycle per accepted request. `word` changes only in that cycle and holds until the next result.
- R9: A `start` that arrives while a request is in progress is ignored. The result then belongs to the request already running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, taken only when idle |
| period_ps | input | 32 | Requested clock period in picoseconds, sampled with `start` |
| word | output | 16 | Packed N, K and M of the best candidate |
| done | output | 1 | One-cycle result strobe |

## Verification
The assertions assume that `start` is a single-cycle pulse and that `period_ps` is valid in the cycle `start` is high. They also assume the divider sees no other request while a division is running. Integer floor semantics hold only under these conditions. The stimulus holds `start` for exactly one cycle and drives the period at the same moment. Repeat requests are issued only after `done`, except for one deliberate mid-scan `start` that exercises the ignore rule. Random periods are drawn from the range that maps into the clamping band. Directed periods cover zero, the lower clamp, the upper clamp and the zero-frequency case.

// File: rtl/mnsrch_pkg.sv
package mnsrch_pkg;

  localparam int unsigned FREQ_NUMER = 32'd100000000;
  localparam int unsigned FREQ_LO    = 32'd8000;
  localparam int unsigned FREQ_HI    = 32'd15938;
  localparam int unsigned VCO_FLOOR  = FREQ_LO * 32'd8;
  localparam int unsigned REF_SCALED = 32'd938356;
  localparam logic [15:0] ZERO_WORD  = 16'h00E0;
  localparam int          K_W        = 3;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FDIV  = 3'd1,
    ST_CGO   = 3'd2,
    ST_CWAIT = 3'd3,
    ST_PACK  = 3'd4
  } scan_state_e;

  // Limit a request to the supported band.
  function automatic logic [31:0] clamp_freq(input logic [31:0] f);
    if (f < FREQ_LO)      return FREQ_LO;
    else if (f > FREQ_HI) return FREQ_HI;
    else                  return f;
  endfunction

  // Number of doublings until the value reaches the VCO floor.
  function automatic logic [K_W-1:0] post_exp(input logic [31:0] f);
    logic [31:0]    v;
    logic [K_W-1:0] k;
    v = f;
    k = '0;
    for (int i = 0; i < 7; i++) begin
      if (v < VCO_FLOOR) begin
        v = v << 1;
        k = k + K_W'(1);
      end
    end
    return k;
  endfunction

  // Comparison target: request scaled to 8 fractional bits of MHz.
  function automatic logic [31:0] target_of(input logic [31:0] f);
    return (f * 32'd256) / 32'd100;
  endfunction

  // Numerator after the power-of-two part of the divisor is shifted out.
  function automatic logic [31:0] cand_numer(input logic [31:0] n,
                                             input logic [K_W-1:0] k);
    logic [31:0] p;
    p = REF_SCALED * (n + 32'd8);
    return p >> (32'd8 + 32'(k));
  endfunction

  function automatic logic [15:0] pack_word(input logic [31:0] k,
                                            input logic [31:0] m,
                                            input logic [31:0] n);
    return 16'((k << 6) + m + (n << 8));
  endfunction

endpackage

// File: rtl/mnsrch_seqdiv.sv
module mnsrch_seqdiv #(
  parameter int NUM_W = 20,
  parameter int DEN_W = 6,
  parameter int STEPS = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic [NUM_W-1:0] quot,
  output logic             done
);
  localparam int ITERS = NUM_W / STEPS;
  localparam int CW    = $clog2(ITERS + 1);
  localparam int WP    = NUM_W + DEN_W + 1;

  logic [NUM_W-1:0] q_r, num_r;
  logic [DEN_W:0]   rem_r;
  logic [DEN_W-1:0] den_r;
  logic [CW-1:0]    left_r;
  logic             done_r;

  logic [DEN_W:0]   rem_c [STEPS+1];
  logic [NUM_W-1:0] q_c   [STEPS+1];

  assign rem_c[0] = rem_r;
  assign q_c[0]   = q_r;

  // One restoring step per stage; STEPS stages run in a cycle.
  for (genvar s = 0; s < STEPS; s++) begin : g_stage
    logic [DEN_W:0] sh;
    logic           fits;
    assign sh           = {rem_c[s][DEN_W-1:0], q_c[s][NUM_W-1]};
    assign fits         = (sh >= {1'b0, den_r});
    assign rem_c[s+1]   = fits ? (sh - {1'b0, den_r}) : sh;
    assign q_c[s+1]     = {q_c[s][NUM_W-2:0], fits};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_r    <= '0;
      num_r  <= '0;
      rem_r  <= '0;
      den_r  <= '0;
      left_r <= '0;
      done_r <= 1'b0;
    end else if (start) begin
      q_r    <= num;
      num_r  <= num;
      rem_r  <= '0;
      den_r  <= den;
      left_r <= CW'(ITERS);
      done_r <= 1'b0;
    end else if (left_r != '0) begin
      q_r    <= q_c[STEPS];
      rem_r  <= rem_c[STEPS];
      left_r <= left_r - CW'(1);
      done_r <= (left_r == CW'(1));
    end else begin
      done_r <= 1'b0;
    end
  end

  assign quot = q_r;
  assign done = done_r;

  // Reconstruction of the dividend from quotient and remainder.
  logic [WP-1:0] recon;
  assign recon = WP'(q_r) * WP'(den_r) + WP'(rem_r);

  a_r6_div_exact: assert property (@(posedge clk) disable iff (!rst_n)
    (done_r && den_r != '0) |-> (recon == WP'(num_r)));

endmodule

// File: rtl/mnsrch_best.sv
module mnsrch_best #(
  parameter int QW  = 20,
  parameter int M_W = 5,
  parameter int N_W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clear,
  input  logic           cand_vld,
  input  logic [31:0]    target,
  input  logic [QW-1:0]  cand_q,
  input  logic [M_W-1:0] cand_m,
  input  logic [N_W-1:0] cand_n,
  output logic [M_W-1:0] best_m,
  output logic [N_W-1:0] best_n
);
  logic [31:0] cand32, err, best_err;
  logic        take;

  assign cand32 = 32'(cand_q);
  assign err    = (target > cand32) ? (target - cand32) : (cand32 - target);
  // Strict comparison keeps the earliest minimum.
  assign take   = cand_vld && (err < best_err);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      best_err <= '1;
      best_m   <= '0;
      best_n   <= '0;
    end else if (take) begin
      best_err <= err;
      best_m   <= cand_m;
      best_n   <= cand_n;
    end
  end

  a_r7_err_nonincreasing: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> (best_err <= $past(best_err)));

  a_r7_take_records: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !clear) |=> (best_m == $past(cand_m) && best_n == $past(cand_n)));

  a_r7_tie_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_vld && !clear && err == best_err) |=> $stable(best_m) && $stable(best_n));

endmodule

// File: rtl/mn_search_engine.sv
module mn_search_engine
  import mnsrch_pkg::*;
#(
  parameter int M_MIN      = 2,
  parameter int M_MAX      = 30,
  parameter int N_MIN      = 35,
  parameter int N_MAX      = 247,
  parameter int CAND_STEPS = 20,
  parameter int FREQ_STEPS = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] period_ps,
  output logic [15:0] word,
  output logic        done
);
  localparam int     M_W      = $clog2(M_MAX + 1);
  localparam int     N_W      = $clog2(N_MAX + 1);
  localparam int     DEN_W    = $clog2(M_MAX + 3);
  localparam longint NUM_PEAK = (longint'(REF_SCALED) * longint'(N_MAX + 8)) >>> 8;
  localparam int     CNUM_W   = $clog2(NUM_PEAK + 1);
  localparam int     CNUM_PAD = ((CNUM_W + CAND_STEPS - 1) / CAND_STEPS) * CAND_STEPS;

  scan_state_e    st;
  logic [15:0]    word_q;
  logic           done_q;
  logic [M_W-1:0] m_r;
  logic [N_W-1:0] n_r;
  logic [K_W-1:0] k_r;
  logic [31:0]    tgt_r;

  // Named internal events
  logic             fdiv_start, fdiv_done, freq_zero;
  logic [31:0]      freq_now, freq_clamped;
  logic             cand_start, cand_done, cand_vld, scan_last, trk_clear;
  logic [CNUM_PAD-1:0] cand_num, cand_q;
  logic [DEN_W-1:0] cand_den;
  logic [M_W-1:0]   best_m;
  logic [N_W-1:0]   best_n;

  assign fdiv_start   = start && (st == ST_IDLE);
  assign freq_zero    = (freq_now == 32'd0);
  assign freq_clamped = clamp_freq(freq_now);
  assign trk_clear    = (st == ST_FDIV) && fdiv_done;
  assign cand_start   = (st == ST_CGO);
  assign cand_vld     = (st == ST_CWAIT) && cand_done;
  assign scan_last    = (m_r == M_W'(M_MAX)) && (n_r == N_W'(N_MAX));
  assign cand_num     = CNUM_PAD'(cand_numer(32'(n_r), k_r));
  assign cand_den     = DEN_W'(m_r) + DEN_W'(2);

  mnsrch_seqdiv #(.NUM_W(32), .DEN_W(32), .STEPS(FREQ_STEPS)) u_fdiv (
    .clk   (clk),
    .rst_n (rst_n),
    .start (fdiv_start),
    .num   (FREQ_NUMER),
    .den   (period_ps),
    .quot  (freq_now),
    .done  (fdiv_done)
  );

  mnsrch_seqdiv #(.NUM_W(CNUM_PAD), .DEN_W(DEN_W), .STEPS(CAND_STEPS)) u_cdiv (
    .clk   (clk),
    .rst_n (rst_n),
    .start (cand_start),
    .num   (cand_num),
    .den   (cand_den),
    .quot  (cand_q),
    .done  (cand_done)
  );

  mnsrch_best #(.QW(CNUM_PAD), .M_W(M_W), .N_W(N_W)) u_best (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (trk_clear),
    .cand_vld (cand_vld),
    .target   (tgt_r),
    .cand_q   (cand_q),
    .cand_m   (m_r),
    .cand_n   (n_r),
    .best_m   (best_m),
    .best_n   (best_n)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      word_q <= '0;
      done_q <= 1'b0;
      m_r    <= M_W'(M_MIN);
      n_r    <= N_W'(N_MIN);
      k_r    <= '0;
      tgt_r  <= '0;
    end else begin
      done_q <= 1'b0;
      case (st)
        ST_IDLE: if (start) st <= ST_FDIV;
        ST_FDIV: if (fdiv_done) begin
          if (freq_zero) begin
            word_q <= ZERO_WORD;
            done_q <= 1'b1;
            st     <= ST_IDLE;
          end else begin
            k_r   <= post_exp(freq_clamped);
            tgt_r <= target_of(freq_clamped);
            m_r   <= M_W'(M_MIN);
            n_r   <= N_W'(N_MIN);
            st    <= ST_CGO;
          end
        end
        ST_CGO: st <= ST_CWAIT;
        ST_CWAIT: if (cand_done) begin
          if (scan_last) begin
            st <= ST_PACK;
          end else begin
            if (n_r == N_W'(N_MAX)) begin
              n_r <= N_W'(N_MIN);
              m_r <= m_r + M_W'(1);
            end else begin
              n_r <= n_r + N_W'(1);
            end
            st <= ST_CGO;
          end
        end
        ST_PACK: begin
          word_q <= pack_word(32'(k_r), 32'(best_m), 32'(best_n));
          done_q <= 1'b1;
          st     <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign word = word_q;
  assign done = done_q;

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  a_r8_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q |-> $stable(word_q));

  a_r7_index_range: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CWAIT) |-> (m_r >= M_W'(M_MIN) && m_r <= M_W'(M_MAX) &&
                          n_r >= N_W'(N_MIN) && n_r <= N_W'(N_MAX)));

  a_r3_zero_word: assert property (@(posedge clk) disable iff (!rst_n)
    (trk_clear && freq_zero) |=> (done_q && word_q == ZERO_WORD));

  a_r5_k_in_band: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CGO) |-> (k_r == K_W'(3)));

  a_r9_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CWAIT && !cand_done) |=> (st == ST_CWAIT));

endmodule

// File: tb/sim_mn_search_engine.sv
module sim_mn_search_engine;
  logic        clk;
  logic        rst_n;
  logic        start;
  logic [31:0] period_ps;
  logic [15:0] word;
  logic        done;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  mn_search_engine u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .period_ps (period_ps),
    .word      (word),
    .done      (done)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Independent model: direct division, no shift split.
  function automatic logic [15:0] ref_word(input logic [31:0] per);
    longint f, tgt, fo, diff, best;
    int k, bm, bn;
    if (per == 0) f = 64'hFFFF_FFFF;
    else          f = 100000000 / longint'(per);
    if (f == 0) return 16'h00E0;
    if (f < 8000)  f = 8000;
    if (f > 15938) f = 15938;
    tgt = (f * 256) / 100;
    k = 0;
    while ((f << k) < 64000) k++;
    best = 64'h0000_0000_FFFF_FFFF;
    bm = 0; bn = 0;
    for (int m = 2; m <= 30; m++) begin
      for (int n = 35; n <= 247; n++) begin
        fo = (938356 * longint'(n + 8)) / ((longint'(1) << k) * 256 * longint'(m + 2));
        diff = (tgt > fo) ? tgt - fo : fo - tgt;
        if (diff < best) begin
          best = diff; bm = m; bn = n;
        end
      end
    end
    return 16'((k << 6) + bm + (bn << 8));
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic pulse_start(input logic [31:0] p);
    @(negedge clk);
    start = 1'b1;
    period_ps = p;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int lat);
    lat = 1;
    while (!done && lat < 40000) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic after_result(input logic [15:0] exp, input string req);
    logic [15:0] held;
    check(word == exp, req, "result word", word, exp);
    held = word;
    @(negedge clk);
    check(done == 1'b0, "R8", "done width", done, 0);
    repeat (4) @(negedge clk);
    check(word == held, "R8", "word hold", word, held);
  endtask

  task automatic run_case(input logic [31:0] p, input string req);
    int lat;
    logic [15:0] exp;
    exp = ref_word(p);
    pulse_start(p);
    wait_done(lat);
    check(done == 1'b1, req, "done seen", done, 1);
    after_result(exp, req);
  endtask

  initial begin
    int lat;
    logic [15:0] exp;
    void'($urandom(32'd2718));
    start = 1'b0;
    period_ps = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R1", "done in reset", done, 0);
    check(word == 16'h0, "R1", "word in reset", word, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(done == 1'b0 && word == 16'h0, "R1", "after release", word, 0);

    // R3: zero frequency, no scan
    pulse_start(32'd200000000);
    wait_done(lat);
    check(done == 1'b1 && lat <= 16, "R3", "quick done latency", lat, 16);
    after_result(16'h00E0, "R3");

    // R4: lower clamp and upper clamp
    run_case(32'd20000, "R4");
    run_case(32'd1000, "R4");
    // R2: zero period clamps high; in-band exact division
    run_case(32'd0, "R2");
    run_case(32'd6275, "R2");
    check(word[7:6] == 2'd3 && word[5] == 1'b0, "R5", "K field", word[7:6], 3);
    check(word[4:0] >= 5'd2 && word[4:0] <= 5'd30 && word[15:8] >= 8'd35 && word[15:8] <= 8'd247,
          "R7", "indices in scan range", word, 0);

    // R9: start during a scan is ignored
    exp = ref_word(32'd9000);
    check(exp != ref_word(32'd7000), "R9", "distinct stimulus", exp, 0);
    pulse_start(32'd9000);
    repeat (200) @(negedge clk);
    pulse_start(32'd7000);
    wait_done(lat);
    after_result(exp, "R9");

    // R6 R7: random in-band periods
    for (int i = 0; i < 2; i++) begin
      logic [31:0] p;
      p = 32'd6275 + ($urandom % 32'd6225);
      run_case(p, "R6");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule